// File: doc/BRIEF.md
# SD/MMC Command Response Capture

This block issues a single card command and turns whatever the card returns into response words and an outcome pulse. The host writes an 11-bit command word together with a 32-bit argument. When the word asks for the command to go out, the block offers the index and the argument on a request port with a valid/ready handshake. It then collects the bytes the card streams back until the card marks the end of the response.

The number of bytes collected is checked against the response shape the command asked for. Valid data is packed most-significant byte first into four 32-bit response words. The block then raises exactly one of three one-cycle set pulses, placed at the bit positions of a neighbouring sticky status register: command sent, response received, or timeout. A card that stays silent for longer than a parameterised number of cycles also ends in a timeout. The serial line protocol, the CRC and the card itself lie outside this block.

Top module: `cmd_resp_capture`

## Requirements
- R1: After reset the block is idle and not busy, no request is offered, the command register reads zero, all response words are zero and no flag pulse is present.
- R2: The command word uses index [5:0], response expected [6], long response [7], interrupt mode [8], pending [9] and enable [10]. An idle write with enable set and pending clear issues one request carrying the index and the argument, and holds it until ready is seen.
- R3: An idle write with both enable and pending set issues no request and raises no flag. One cycle later the command register reads back the written word with enable cleared.
- R4: An idle write with enable clear is stored as written, and no request is issued.
- R5: When response expected is clear, the block pulses the sent flag (bit 7) whatever the returned length, and the response words keep their previous values.
- R6: When response expected is set, a 4-byte return with long clear, or a 16-byte return with either long setting, pulses the response flag (bit 6). A 4-byte return fills word 0 most-significant byte first and clears words 1 to 3. A 16-byte return fills words 0 to 3 in byte order, with bit 0 of word 3 forced to zero.
- R7: When response expected is set, a return of 0 bytes, of 4 bytes with long set, or of any length other than 4 or 16 pulses the timeout flag (bit 2), and the response words are unchanged.
- R8: If the end of the response has not arrived LAT_MAX cycles after the issuing write, the timeout flag pulses, the request is withdrawn and the response words are unchanged.
- R9: Each issued command gives exactly one flag pulse, one cycle long, in the cycle after the end marker is taken. The enable bit reads 1 while the block is busy and reads 0 from that pulse onward.
- R10: The interrupt-mode bit (8) has no effect on issue, outcome or response words.
- R11: Command writes made while the block is busy are ignored. Index, argument and command register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 11 | Command word to write |
| arg_i | input | ARG_W | Argument captured with the write |
| cmd_reg_o | output | 11 | Command register readback |
| busy_o | output | 1 | A command is in flight |
| req_valid_o | output | 1 | Request offered to the card |
| req_ready_i | input | 1 | Card accepts the request |
| req_index_o | output | 6 | Command index on the request |
| req_arg_o | output | ARG_W | Argument on the request |
| rsp_byte_valid_i | input | 1 | A response byte is present |
| rsp_byte_i | input | 8 | Response byte |
| rsp_end_i | input | 1 | End of the response stream |
| resp_o | output | WORD_W*N_WORDS | Response words, word j at [j*WORD_W +: WORD_W] |
| flag_set_o | output | 8 | One-cycle set pulses: bit 2 timeout, bit 6 response, bit 7 sent |

## Verification
The bench keeps the 32-bit word and four-word response shape and sets LAT_MAX to 40, far below the default of 256. That makes the silent-card timeout reachable in a few dozen cycles, so its exact cycle can be checked both before and after the request is accepted. With this setting the longest stream in the table, 17 bytes, still finishes well inside the bound. The bench therefore separates length-based timeouts from latency timeouts, and it chooses byte patterns that make the forced-zero last bit visible.

// File: rtl/cmdcap_pkg.sv
package cmdcap_pkg;
  localparam int CMD_W  = 11;
  localparam int IDX_W  = 6;
  localparam int B_RESP = 6;
  localparam int B_LONG = 7;
  localparam int B_INTR = 8;
  localparam int B_PEND = 9;
  localparam int B_EN   = 10;

  localparam int STAT_W    = 8;
  localparam int F_TIMEOUT = 2;
  localparam int F_RESPEND = 6;
  localparam int F_SENT    = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} cap_state_e;
  typedef enum logic [1:0] {OUT_SENT, OUT_RESP, OUT_TIMEOUT} outcome_e;
endpackage

// File: rtl/cmdcap_collect.sv
module cmdcap_collect #(
  parameter int BYTES = 16,
  parameter int CNT_W = 5,
  localparam int BUF_W = 8 * BYTES,
  localparam logic [CNT_W-1:0] CNT_TOP = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [7:0]       byte_i,
  output logic [BUF_W-1:0] buf_o,
  output logic [CNT_W-1:0] cnt_o
);
  // shift register: first byte ends in the top byte after BYTES pushes
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      buf_o <= '0;
      cnt_o <= '0;
    end else if (push_i) begin
      buf_o <= {buf_o[BUF_W-9:0], byte_i};
      if (cnt_o != CNT_TOP) cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_TOP && push_i && !clr_i) |=> (cnt_o == CNT_TOP)); // R7
endmodule

// File: rtl/cmdcap_judge.sv
module cmdcap_judge
  import cmdcap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int N_WORDS = 4,
  parameter int CNT_W = 5,
  localparam int SHORT_B = WORD_W / 8,
  localparam int LONG_B = N_WORDS * SHORT_B,
  localparam int RESP_W = WORD_W * N_WORDS
) (
  input  logic              resp_exp_i,
  input  logic              long_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [RESP_W-1:0] buf_i,
  output outcome_e          outcome_o,
  output logic [RESP_W-1:0] words_o
);
  logic [RESP_W-1:0] long_words;
  logic is_short, is_long;

  for (genvar j = 0; j < N_WORDS; j++) begin : g_word
    if (j == N_WORDS - 1) begin : g_last
      assign long_words[j*WORD_W +: WORD_W] =
        {buf_i[RESP_W-1-j*WORD_W -: WORD_W-1], 1'b0};
    end else begin : g_mid
      assign long_words[j*WORD_W +: WORD_W] = buf_i[RESP_W-1-j*WORD_W -: WORD_W];
    end
  end

  assign is_short = (cnt_i == CNT_W'(SHORT_B));
  assign is_long  = (cnt_i == CNT_W'(LONG_B));

  always_comb begin
    words_o = is_long ? long_words : {{(RESP_W-WORD_W){1'b0}}, buf_i[WORD_W-1:0]};
    if (!resp_exp_i)                 outcome_o = OUT_SENT;
    else if (is_long)                outcome_o = OUT_RESP;
    else if (is_short && !long_i)    outcome_o = OUT_RESP;
    else                             outcome_o = OUT_TIMEOUT;
  end
endmodule

// File: rtl/cmd_resp_capture.sv
module cmd_resp_capture
  import cmdcap_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 4,
  parameter int ARG_W   = 32,
  parameter int LAT_MAX = 256,
  localparam int RESP_W = WORD_W * N_WORDS,
  localparam int LONG_B = RESP_W / 8,
  localparam int CNT_W  = $clog2(LONG_B + 2),
  localparam int TMR_W  = $clog2(LAT_MAX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic [ARG_W-1:0]  arg_i,
  output logic [CMD_W-1:0]  cmd_reg_o,
  output logic              busy_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [IDX_W-1:0]  req_index_o,
  output logic [ARG_W-1:0]  req_arg_o,
  input  logic              rsp_byte_valid_i,
  input  logic [7:0]        rsp_byte_i,
  input  logic              rsp_end_i,
  output logic [RESP_W-1:0] resp_o,
  output logic [STAT_W-1:0] flag_set_o
);
  localparam logic [CMD_W-1:0] EN_MASK = CMD_W'(1) << B_EN;

  cap_state_e        state_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [ARG_W-1:0]  arg_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [RESP_W-1:0] resp_q;
  logic [STAT_W-1:0] flag_q;
  logic              start, push, tmr_end;
  logic [RESP_W-1:0] cap_buf, words;
  logic [CNT_W-1:0]  cap_cnt;
  outcome_e          verdict;

  assign start   = (state_q == ST_IDLE) && cmd_wr_i &&
                   cmd_wdata_i[B_EN] && !cmd_wdata_i[B_PEND];
  assign push    = (state_q == ST_WAIT) && rsp_byte_valid_i && !rsp_end_i;
  assign tmr_end = (tmr_q == TMR_W'(LAT_MAX - 1));

  cmdcap_collect #(.BYTES(LONG_B), .CNT_W(CNT_W)) u_collect (
    .clk(clk), .rst(rst), .clr_i(start), .push_i(push),
    .byte_i(rsp_byte_i), .buf_o(cap_buf), .cnt_o(cap_cnt)
  );

  cmdcap_judge #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .CNT_W(CNT_W)) u_judge (
    .resp_exp_i(cmd_q[B_RESP]), .long_i(cmd_q[B_LONG]), .cnt_i(cap_cnt),
    .buf_i(cap_buf), .outcome_o(verdict), .words_o(words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      arg_q   <= '0;
      tmr_q   <= '0;
      resp_q  <= '0;
      flag_q  <= '0;
    end else begin
      flag_q <= '0;
      if (!tmr_end) tmr_q <= tmr_q + TMR_W'(1);
      case (state_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (cmd_wr_i) begin
            arg_q <= arg_i;
            cmd_q <= start ? cmd_wdata_i : (cmd_wdata_i & ~EN_MASK);
            if (start) state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (req_ready_i) begin
            state_q <= ST_WAIT;
          end else if (tmr_end) begin
            state_q           <= ST_IDLE;
            cmd_q[B_EN]       <= 1'b0;
            flag_q[F_TIMEOUT] <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (rsp_end_i) begin
            state_q     <= ST_IDLE;
            cmd_q[B_EN] <= 1'b0;
            case (verdict)
              OUT_SENT: flag_q[F_SENT] <= 1'b1;
              OUT_RESP: begin
                flag_q[F_RESPEND] <= 1'b1;
                resp_q            <= words;
              end
              default:  flag_q[F_TIMEOUT] <= 1'b1;
            endcase
          end else if (tmr_end) begin
            state_q           <= ST_IDLE;
            cmd_q[B_EN]       <= 1'b0;
            flag_q[F_TIMEOUT] <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_reg_o   = cmd_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign req_valid_o = (state_q == ST_REQ);
  assign req_index_o = cmd_q[IDX_W-1:0];
  assign req_arg_o   = arg_q;
  assign resp_o      = resp_q;
  assign flag_set_o  = flag_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=> (req_valid_o || flag_set_o[F_TIMEOUT])); // R2
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_set_o)); // R9
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (flag_set_o != '0) |-> !cmd_reg_o[B_EN]); // R9
  AST_LAST_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flag_set_o[F_RESPEND] |-> !resp_o[(N_WORDS-1)*WORD_W]); // R6
  AST_BUSY_SHIELD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cmd_wr_i) |=> ($stable(req_arg_o) && $stable(req_index_o))); // R11
  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    tmr_q <= TMR_W'(LAT_MAX - 1)); // R8
endmodule

// File: tb/cmd_resp_capture_bench.sv
module cmd_resp_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 40;
  localparam int RW = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_wr = 1'b0;
  logic [10:0]  cmd_wdata = '0;
  logic [31:0]  arg = '0;
  logic [10:0]  cmd_reg;
  logic         busy, req_valid, req_ready = 1'b0;
  logic [5:0]   req_index;
  logic [31:0]  req_arg;
  logic         bvalid = 1'b0, rend = 1'b0;
  logic [7:0]   bdata = '0;
  logic [RW-1:0] resp;
  logic [7:0]   flags;

  int n_chk = 0;
  int n_bad = 0;
  logic [RW-1:0] exp_resp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_resp_capture #(.LAT_MAX(LAT)) u_cmd_resp_capture (
    .clk(clk), .rst(rst), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata), .arg_i(arg),
    .cmd_reg_o(cmd_reg), .busy_o(busy), .req_valid_o(req_valid), .req_ready_i(req_ready),
    .req_index_o(req_index), .req_arg_o(req_arg), .rsp_byte_valid_i(bvalid),
    .rsp_byte_i(bdata), .rsp_end_i(rend), .resp_o(resp), .flag_set_o(flags)
  );

  // {seed[7:0], nbytes[7:0], 3'b0, kind[1:0], cmd[10:0]}; kind 0 sent, 1 response, 2 timeout
  localparam logic [31:0] VEC [13] = '{
    {8'h11, 8'd4,  3'b0, 2'd1, 11'h442},
    {8'h20, 8'd16, 3'b0, 2'd1, 11'h4C9},
    {8'h05, 8'd0,  3'b0, 2'd2, 11'h443},
    {8'h06, 8'd4,  3'b0, 2'd2, 11'h4CA},
    {8'h07, 8'd8,  3'b0, 2'd2, 11'h445},
    {8'h08, 8'd0,  3'b0, 2'd0, 11'h400},
    {8'h09, 8'd4,  3'b0, 2'd0, 11'h407},
    {8'h3C, 8'd16, 3'b0, 2'd1, 11'h451},
    {8'h0A, 8'd17, 3'b0, 2'd2, 11'h4D2},
    {8'h7E, 8'd4,  3'b0, 2'd1, 11'h577},
    {8'h01, 8'd16, 3'b0, 2'd1, 11'h4FF},
    {8'h0B, 8'd16, 3'b0, 2'd0, 11'h501},
    {8'h0C, 8'd0,  3'b0, 2'd2, 11'h4C4}
  };

  function automatic logic [7:0] bval(input logic [7:0] s, input int k);
    return s + 8'(k * 37);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act,
                     input logic [RW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic wr_cmd(input logic [10:0] c, input logic [31:0] a);
    cmd_wr = 1'b1; cmd_wdata = c; arg = a;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic run_vec(input int i);
    logic [10:0] c;
    logic [7:0] s;
    int nb, kind;
    logic [7:0] ef;
    logic [31:0] a;
    string tg;
    c = VEC[i][10:0]; kind = int'(VEC[i][12:11]); nb = int'(VEC[i][23:16]); s = VEC[i][31:24];
    a = {s, ~s, 8'(i), 8'h5A};
    tg = (kind == 0) ? "R5" : (kind == 1) ? "R6" : "R7";
    if (c[8]) tg = {tg, "/R10"};
    ef = (kind == 0) ? 8'h80 : (kind == 1) ? 8'h40 : 8'h04;
    wr_cmd(c, a);
    chk(busy && cmd_reg[10], "R9 busy/enable while in flight", RW'({busy, cmd_reg[10]}), RW'(2'b11));
    chk(req_valid && req_index == c[5:0] && req_arg == a, "R2 request fields",
        RW'({req_valid, req_index, req_arg}), RW'({1'b1, c[5:0], a}));
    @(negedge clk);
    chk(req_valid, "R2 request held without ready", RW'(req_valid), RW'(1));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int k = 0; k < nb; k++) begin
      bvalid = 1'b1; bdata = bval(s, k);
      @(negedge clk);
    end
    bvalid = 1'b0; rend = 1'b1;
    @(negedge clk);
    rend = 1'b0;
    if (kind == 1) begin
      if (nb == 16) begin
        for (int j = 0; j < 4; j++)
          exp_resp[j*32 +: 32] = {bval(s, 4*j), bval(s, 4*j+1), bval(s, 4*j+2), bval(s, 4*j+3)};
        exp_resp[96] = 1'b0;
      end else begin
        exp_resp = '0;
        exp_resp[31:0] = {bval(s, 0), bval(s, 1), bval(s, 2), bval(s, 3)};
      end
    end
    chk(flags == ef, {tg, " outcome flag"}, RW'(flags), RW'(ef));
    chk(resp == exp_resp, {tg, " response words"}, resp, exp_resp);
    chk(!cmd_reg[10] && !busy, "R9 enable cleared at pulse", RW'({cmd_reg[10], busy}), '0);
    @(negedge clk);
    chk(flags == 8'h00, "R9 pulse lasts one cycle", RW'(flags), '0);
  endtask

  task automatic silent(input bit accept);
    int cnt;
    cnt = 0;
    wr_cmd(11'h443, 32'hCAFE_0001);
    if (accept) req_ready = 1'b1;
    for (int k = 0; k < LAT + 5; k++) begin
      @(negedge clk);
      req_ready = 1'b0;
      cnt++;
      if (flags != 8'h00) break;
    end
    chk(cnt == LAT, "R8 timeout cycle", RW'(cnt), RW'(LAT));
    chk(flags == 8'h04, "R8 timeout flag", RW'(flags), RW'(8'h04));
    chk(!req_valid && !busy, "R8 request withdrawn", RW'({req_valid, busy}), '0);
    chk(resp == exp_resp, "R8 response unchanged", resp, exp_resp);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !req_valid && cmd_reg == '0 && resp == '0 && flags == '0, "R1 reset state",
        RW'({busy, req_valid, cmd_reg, flags}) | resp, '0);

    for (int i = 0; i < 13; i++) run_vec(i);

    // R4: enable clear stores the word, no request
    wr_cmd(11'h0C7, 32'h1234_5678);
    chk(cmd_reg == 11'h0C7 && !busy && !req_valid, "R4 stored without issue",
        RW'({cmd_reg, busy, req_valid}), RW'({11'h0C7, 2'b00}));
    // R3: pending set suppresses issue
    wr_cmd(11'h645, 32'h0);
    chk(cmd_reg == 11'h245 && !busy && !req_valid && flags == '0, "R3 pending not issued",
        RW'({cmd_reg, busy, req_valid, flags}), RW'({11'h245, 10'b0}));
    @(negedge clk);
    chk(flags == '0 && !req_valid, "R3 no flag later", RW'({flags, req_valid}), '0);

    // R11: write during busy is ignored
    wr_cmd(11'h442, 32'hABCD_0011);
    wr_cmd(11'h7FF, 32'hFFFF_FFFF);
    chk(cmd_reg == 11'h442 && req_index == 6'd2 && req_arg == 32'hABCD_0011,
        "R11 busy write ignored", RW'({cmd_reg, req_index, req_arg}),
        RW'({11'h442, 6'd2, 32'hABCD_0011}));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bvalid = 1'b1; bdata = 8'hA0 + 8'(k);
      @(negedge clk);
    end
    bvalid = 1'b0; rend = 1'b1;
    @(negedge clk);
    rend = 1'b0;
    exp_resp = '0; exp_resp[31:0] = 32'hA0A1_A2A3;
    chk(flags == 8'h40 && resp == exp_resp, "R11 command completes normally",
        resp, exp_resp);
    @(negedge clk);

    silent(1'b0);
    silent(1'b1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule